// File: doc/BRIEF.md
# Pin Interrupt and DMA Event Detector

This block watches a bank of general-purpose input pins and turns selected pin activity into either interrupt or DMA request events. Each pin has a 4-bit mode code. The code picks one of three kinds of trigger: an edge that raises a DMA request, an edge that raises an interrupt, or a pin level that raises an interrupt. Every pin input first passes through a synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier. The detector ignores whatever function the pin is routed to elsewhere.

Each pin keeps one sticky event flag. For a pin in a DMA mode, that flag drives the pin's DMA request line, and a transfer-complete pulse clears it. For a pin in an interrupt mode, the flag feeds a single combined interrupt line, and only software can clear it, by writing a one to the flag's bit. A level-triggered interrupt whose level is still present after a clear sets its flag again one cycle later. Software reads all flags at once through a registered read port. Bit i of the read word and of every vector port belongs to pin i.

Top module: `pin_event_detector`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all flags, `rd_data`, `irq` and `dma_req` are 0.
- R2: Mode codes 0001, 0010 and 0011 set the pin's flag on a rising edge, a falling edge, or either edge of the synchronized pin. The flag then appears on `dma_req[i]`.
- R3: Mode codes 1001, 1010 and 1011 set the pin's flag on a rising edge, a falling edge, or either edge. The flag then contributes to `irq`.
- R4: Mode code 1000 sets the flag in every cycle in which the synchronized pin is 0, and code 1100 does so while it is 1. A software clear applied while the level persists drops the flag for exactly one cycle, after which the flag is set again.
- R5: A cycle with `clr_we` high clears flag i when `clr_data[i]` is 1. A 0 in `clr_data[i]`, or `clr_we` low, leaves flag i unchanged.
- R6: A `dma_done[i]` pulse clears flag i while pin i is in a DMA mode (0001 to 0011). In any other mode the pulse has no effect on the flag.
- R7: Code 0000 and the unused codes (0100 to 0111, 1101 to 1111) never set a flag, whatever the pin does.
- R8: If an edge event and a clear (software or DMA) reach the same flag in the same cycle, the flag ends up set.
- R9: `irq` is the OR of the flags of pins in interrupt modes (1000 to 1100). `dma_req[i]` is flag i while pin i is in a DMA mode. Both are registered and follow the flags by one cycle.
- R10: The flag sets on the third clock edge after the pin change is first sampled. `rd_data`, `irq` and `dma_req` reflect it one edge later.
- R11: On each clock edge with `rd_en` high, `rd_data` captures the flag vector. With `rd_en` low, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_cfg | input | NUM_PINS*4 | Mode code per pin; pin i uses bits [4i+3:4i] |
| clr_we | input | 1 | Software clear strobe |
| clr_data | input | NUM_PINS | Write-one-to-clear mask |
| dma_done | input | NUM_PINS | Per-pin transfer-complete pulse |
| rd_en | input | 1 | Read capture enable |
| rd_data | output | NUM_PINS | Captured flag vector |
| irq | output | 1 | Combined interrupt |
| dma_req | output | NUM_PINS | Per-pin DMA request |

## Verification
A new edge event and a clear can land on the same flag in the same cycle. The test provokes this by making an either-edge interrupt pin toggle a second time while its flag is still set. It times a software clear to hit the exact edge at which the second event is registered, and expects the flag to survive into the read word. A level interrupt meets a clear in the same cycle in a different way: the test expects a one-cycle dip in the flag followed by an immediate re-set, sampled on consecutive read cycles.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    MODE_OFF      = 4'b0000,
    MODE_DMA_RISE = 4'b0001,
    MODE_DMA_FALL = 4'b0010,
    MODE_DMA_BOTH = 4'b0011,
    MODE_IRQ_LOW  = 4'b1000,
    MODE_IRQ_RISE = 4'b1001,
    MODE_IRQ_FALL = 4'b1010,
    MODE_IRQ_BOTH = 4'b1011,
    MODE_IRQ_HIGH = 4'b1100
  } pin_mode_e;

  function automatic logic mode_is_dma(input logic [CODE_W-1:0] code);
    return (code == MODE_DMA_RISE) || (code == MODE_DMA_FALL) ||
           (code == MODE_DMA_BOTH);
  endfunction

  function automatic logic mode_is_irq(input logic [CODE_W-1:0] code);
    return (code == MODE_IRQ_LOW)  || (code == MODE_IRQ_RISE) ||
           (code == MODE_IRQ_FALL) || (code == MODE_IRQ_BOTH) ||
           (code == MODE_IRQ_HIGH);
  endfunction

  function automatic logic mode_edge(input logic [CODE_W-1:0] code);
    return (code == MODE_DMA_RISE) || (code == MODE_DMA_FALL) ||
           (code == MODE_DMA_BOTH) || (code == MODE_IRQ_RISE) ||
           (code == MODE_IRQ_FALL) || (code == MODE_IRQ_BOTH);
  endfunction

  function automatic logic mode_on_rise(input logic [CODE_W-1:0] code);
    return mode_edge(code) && code[0];
  endfunction

  function automatic logic mode_on_fall(input logic [CODE_W-1:0] code);
    return mode_edge(code) && code[1];
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int NUM_PINS = 8,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_async,
  output logic [NUM_PINS-1:0] level,
  output logic [NUM_PINS-1:0] level_prev
);

  localparam int LAST = STAGES - 1;

  logic [NUM_PINS-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) level_prev <= '0;
    else     level_prev <= chain[LAST];
  end

  assign level = chain[LAST];

endmodule

// File: rtl/evt_decode.sv
module evt_decode
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS-1:0]        level,
  input  logic [NUM_PINS-1:0]        level_prev,
  input  logic [NUM_PINS*CODE_W-1:0] cfg,
  output logic [NUM_PINS-1:0]        edge_hit,
  output logic [NUM_PINS-1:0]        level_hit
);

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic [CODE_W-1:0] code;
      logic              rose, fell, edge_now, lvl_now;

      assign code = cfg[i*CODE_W +: CODE_W];

      always_comb begin
        rose     = level[i] & ~level_prev[i];
        fell     = ~level[i] & level_prev[i];
        edge_now = (rose & mode_on_rise(code)) | (fell & mode_on_fall(code));
        lvl_now  = ((code == MODE_IRQ_LOW)  & ~level[i]) |
                   ((code == MODE_IRQ_HIGH) &  level[i]);
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          edge_hit[i]  <= 1'b0;
          level_hit[i] <= 1'b0;
        end else begin
          edge_hit[i]  <= edge_now;
          level_hit[i] <= lvl_now;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS*CODE_W-1:0] cfg,
  input  logic [NUM_PINS-1:0]        edge_hit,
  input  logic [NUM_PINS-1:0]        level_hit,
  input  logic                       clr_we,
  input  logic [NUM_PINS-1:0]        clr_data,
  input  logic [NUM_PINS-1:0]        dma_done,
  input  logic                       rd_en,
  output logic [NUM_PINS-1:0]        flags,
  output logic [NUM_PINS-1:0]        rd_data,
  output logic                       irq,
  output logic [NUM_PINS-1:0]        dma_req
);

  logic [NUM_PINS-1:0] dma_mask;
  logic [NUM_PINS-1:0] irq_mask;
  logic [NUM_PINS-1:0] flags_nxt;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_flag
      logic [CODE_W-1:0] code;
      logic              sw_clr, hw_clr;

      assign code        = cfg[i*CODE_W +: CODE_W];
      assign dma_mask[i] = mode_is_dma(code);
      assign irq_mask[i] = mode_is_irq(code);

      always_comb begin
        sw_clr = clr_we & clr_data[i];
        hw_clr = dma_done[i] & dma_mask[i];
        if (edge_hit[i])           flags_nxt[i] = 1'b1;
        else if (sw_clr | hw_clr)  flags_nxt[i] = 1'b0;
        else if (level_hit[i])     flags_nxt[i] = 1'b1;
        else                       flags_nxt[i] = flags[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      rd_data <= '0;
      irq     <= 1'b0;
      dma_req <= '0;
    end else begin
      flags   <= flags_nxt;
      irq     <= |(flags & irq_mask);
      dma_req <= flags & dma_mask;
      if (rd_en) rd_data <= flags;
    end
  end

endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS-1:0]        pin_in,
  input  logic [NUM_PINS*CODE_W-1:0] pin_cfg,
  input  logic                       clr_we,
  input  logic [NUM_PINS-1:0]        clr_data,
  input  logic [NUM_PINS-1:0]        dma_done,
  input  logic                       rd_en,
  output logic [NUM_PINS-1:0]        rd_data,
  output logic                       irq,
  output logic [NUM_PINS-1:0]        dma_req
);

  logic [NUM_PINS-1:0] level, level_prev;
  logic [NUM_PINS-1:0] edge_hit, level_hit;
  logic [NUM_PINS-1:0] flag_vec;

  pin_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .pin_async  (pin_in),
    .level      (level),
    .level_prev (level_prev)
  );

  evt_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .level      (level),
    .level_prev (level_prev),
    .cfg        (pin_cfg),
    .edge_hit   (edge_hit),
    .level_hit  (level_hit)
  );

  flag_bank #(.NUM_PINS(NUM_PINS)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .cfg       (pin_cfg),
    .edge_hit  (edge_hit),
    .level_hit (level_hit),
    .clr_we    (clr_we),
    .clr_data  (clr_data),
    .dma_done  (dma_done),
    .rd_en     (rd_en),
    .flags     (flag_vec),
    .rd_data   (rd_data),
    .irq       (irq),
    .dma_req   (dma_req)
  );

endmodule

// File: rtl/pin_event_detector_chk.sv
module pin_event_detector_chk
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_PINS*CODE_W-1:0] pin_cfg,
  input logic                       clr_we,
  input logic [NUM_PINS-1:0]        clr_data,
  input logic [NUM_PINS-1:0]        dma_done,
  input logic                       rd_en,
  input logic [NUM_PINS-1:0]        rd_data,
  input logic                       irq,
  input logic [NUM_PINS-1:0]        dma_req,
  input logic [NUM_PINS-1:0]        edge_hit,
  input logic [NUM_PINS-1:0]        flag_vec
);

  logic [NUM_PINS-1:0] irq_modes;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++)
      irq_modes[i] = mode_is_irq(pin_cfg[i*CODE_W +: CODE_W]);
  end

  assert_reset_clean_R1: assert property (@(posedge clk)
    $fell(rst) |-> (rd_data == '0 && !irq && dma_req == '0 && flag_vec == '0));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (irq == (|$past(flag_vec & irq_modes))));

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !rd_en) |-> $stable(rd_data));

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && edge_hit[i]) |-> flag_vec[i]);

      assert_sw_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && clr_we && clr_data[i] && !edge_hit[i]) |-> !flag_vec[i]);

      assert_done_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && flag_vec[i] && dma_done[i] && !(clr_we && clr_data[i]) &&
              mode_is_irq(pin_cfg[i*CODE_W +: CODE_W])) |-> flag_vec[i]);

      assert_off_never_sets_R7: assert property (@(posedge clk) disable iff (rst)
        $past(!rst, 2) && $rose(flag_vec[i]) |->
          (mode_edge($past(pin_cfg[i*CODE_W +: CODE_W], 2)) ||
           mode_is_irq($past(pin_cfg[i*CODE_W +: CODE_W], 2))));
    end
  endgenerate

endmodule

bind pin_event_detector pin_event_detector_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pin_cfg  (pin_cfg),
  .clr_we   (clr_we),
  .clr_data (clr_data),
  .dma_done (dma_done),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .irq      (irq),
  .dma_req  (dma_req),
  .edge_hit (edge_hit),
  .flag_vec (flag_vec)
);

// File: tb/sim_pin_event_detector.sv
`timescale 1ns/1ps
module sim_pin_event_detector;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_in = '0;
  logic [NP*4-1:0] pin_cfg = '0;
  logic          clr_we = 1'b0;
  logic [NP-1:0] clr_data = '0;
  logic [NP-1:0] dma_done = '0;
  logic          rd_en = 1'b1;
  logic [NP-1:0] rd_data;
  logic          irq;
  logic [NP-1:0] dma_req;

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  typedef struct {
    int         due;
    string      tag;
    logic [7:0] fmask;
    logic [7:0] fval;
    bit         chk_out;
    logic       irqv;
    logic [7:0] dmask;
    logic [7:0] dval;
  } item_t;

  item_t sbq[$];

  pin_event_detector #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_cfg(pin_cfg),
    .clr_we(clr_we), .clr_data(clr_data), .dma_done(dma_done),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .dma_req(dma_req)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push_item(input item_t it);
    int pos = sbq.size();
    for (int k = 0; k < sbq.size(); k++)
      if (sbq[k].due > it.due) begin pos = k; break; end
    sbq.insert(pos, it);
  endtask

  task automatic expf(input int dly, input string tag, input logic [7:0] m, input logic [7:0] v);
    item_t it;
    it.due = cyc + dly; it.tag = tag; it.fmask = m; it.fval = v;
    it.chk_out = 1'b0; it.irqv = 1'b0; it.dmask = '0; it.dval = '0;
    push_item(it);
  endtask

  task automatic expo(input int dly, input string tag, input logic iv, input logic [7:0] dm, input logic [7:0] dv);
    item_t it;
    it.due = cyc + dly; it.tag = tag; it.fmask = '0; it.fval = '0;
    it.chk_out = 1'b1; it.irqv = iv; it.dmask = dm; it.dval = dv;
    push_item(it);
  endtask

  // Scoreboard monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (it.due < cyc) begin
        errors++;
        $display("FAIL %s: check missed its cycle (due %0d, now %0d)", it.tag, it.due, cyc);
      end else if (it.chk_out) begin
        if (irq !== it.irqv || (dma_req & it.dmask) !== (it.dval & it.dmask)) begin
          errors++;
          $display("FAIL %s: irq=%b dma_req=%h, expected irq=%b dma_req=%h (mask %h)",
                   it.tag, irq, dma_req, it.irqv, it.dval, it.dmask);
        end
      end else if ((rd_data & it.fmask) !== (it.fval & it.fmask)) begin
        errors++;
        $display("FAIL %s: rd_data=%h, expected %h (mask %h)", it.tag, rd_data, it.fval, it.fmask);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input int p, input logic [3:0] code);
    pin_cfg[p*4 +: 4] = code;
  endtask

  task automatic dma_pulse(input int p);
    dma_done[p] = 1'b1;
    tick(1);
    dma_done[p] = 1'b0;
  endtask

  task automatic sw_clear(input logic [7:0] m);
    clr_we = 1'b1; clr_data = m;
    tick(1);
    clr_we = 1'b0; clr_data = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung, expected finish");
    finish_run();
  end

  initial begin
    tick(4);
    rst = 1'b0;
    // R1: everything clear right after reset
    expf(1, "R1", 8'hFF, 8'h00);
    expo(1, "R1", 1'b0, 8'hFF, 8'h00);
    tick(3);

    // R2 / R10 / R9: DMA on rising edge, pin 0
    set_mode(0, 4'b0001); tick(3);
    pin_in[0] = 1'b1;
    expf(4, "R10 not yet", 8'h01, 8'h00);
    expf(5, "R2 rise", 8'h01, 8'h01);
    expo(5, "R9 dma only", 1'b0, 8'h01, 8'h01);
    tick(6);
    dma_pulse(0);                                // R6: done clears in DMA mode
    expf(1, "R6 done clears", 8'h01, 8'h00);
    expo(1, "R6 req drops", 1'b0, 8'h01, 8'h00);
    tick(3);

    // R2: falling-edge DMA, pin 1
    set_mode(1, 4'b0010); tick(3);
    pin_in[1] = 1'b1; tick(6);
    expf(1, "R2 fall ignores rise", 8'h02, 8'h00);
    tick(2);
    pin_in[1] = 1'b0;
    expf(5, "R2 fall", 8'h02, 8'h02);
    tick(6);
    dma_pulse(1); tick(2);

    // R2: either-edge DMA, pin 2
    set_mode(2, 4'b0011); tick(3);
    pin_in[2] = 1'b1;
    expf(5, "R2 both rise", 8'h04, 8'h04);
    tick(6); dma_pulse(2); tick(2);
    pin_in[2] = 1'b0;
    expf(5, "R2 both fall", 8'h04, 8'h04);
    tick(6); dma_pulse(2); tick(2);

    // R4: level-low interrupt, pin 3 already low
    set_mode(3, 4'b1000);
    expf(2, "R4 low not yet", 8'h08, 8'h00);
    expf(3, "R4 low", 8'h08, 8'h08);
    expo(3, "R9 irq", 1'b1, 8'h08, 8'h00);
    tick(5);
    sw_clear(8'h08);
    expf(1, "R4 dip", 8'h08, 8'h00);
    expf(2, "R4 reset again", 8'h08, 8'h08);
    tick(3);
    pin_in[3] = 1'b1; tick(6);
    sw_clear(8'h08);
    expf(1, "R5 clear", 8'h08, 8'h00);
    expo(3, "R9 irq drops", 1'b0, 8'h00, 8'h00);
    tick(4);

    // R3 / R5 / R6: rising-edge interrupt, pin 4
    set_mode(4, 4'b1001); tick(3);
    pin_in[4] = 1'b1;
    expf(5, "R3 rise", 8'h10, 8'h10);
    expo(5, "R3 irq no dma", 1'b1, 8'h10, 8'h00);
    tick(6);
    dma_pulse(4);
    expf(1, "R6 done ignored", 8'h10, 8'h10);
    tick(1);
    sw_clear(8'hEF);
    expf(1, "R5 other bits", 8'h10, 8'h10);
    tick(1);
    clr_we = 1'b0; clr_data = 8'h10; tick(1); clr_data = '0;
    expf(1, "R5 no strobe", 8'h10, 8'h10);
    tick(1);
    sw_clear(8'h10);
    expf(1, "R5 w1c", 8'h10, 8'h00);
    tick(3);

    // R8 / R3: either-edge interrupt, pin 5, clear meets second edge
    set_mode(5, 4'b1011); tick(3);
    pin_in[5] = 1'b1;
    expf(5, "R3 both rise", 8'h20, 8'h20);
    tick(6);
    pin_in[5] = 1'b0;
    tick(3);
    sw_clear(8'h20);
    expf(1, "R8 set wins", 8'h20, 8'h20);
    tick(2);
    sw_clear(8'h20);
    expf(1, "R8 later clear", 8'h20, 8'h00);
    tick(3);

    // R7: disabled and unused codes, pin 6
    set_mode(6, 4'b0000); tick(2);
    pin_in[6] = 1'b1; tick(4); pin_in[6] = 1'b0; tick(6);
    expf(1, "R7 off", 8'h40, 8'h00);
    tick(1);
    set_mode(6, 4'b0101); tick(2);
    pin_in[6] = 1'b1; tick(4); pin_in[6] = 1'b0; tick(6);
    set_mode(6, 4'b1110); tick(2);
    pin_in[6] = 1'b1; tick(6);
    expf(1, "R7 unused", 8'h40, 8'h00);
    expo(1, "R7 no irq", 1'b0, 8'h40, 8'h00);
    tick(2);

    // R4: level-high interrupt, pin 7
    set_mode(7, 4'b1100); tick(3);
    expf(1, "R4 high idle", 8'h80, 8'h00);
    tick(1);
    pin_in[7] = 1'b1;
    expf(5, "R4 high", 8'h80, 8'h80);
    tick(6);
    pin_in[7] = 1'b0; tick(6);
    sw_clear(8'h80);
    expf(1, "R4 high cleared", 8'h80, 8'h00);
    tick(3);

    // R11: read capture disabled holds rd_data
    rd_en = 1'b0;
    pin_in[2] = 1'b1; tick(6);
    expo(1, "R11 flag set", 1'b0, 8'h04, 8'h04);
    expf(1, "R11 hold", 8'h04, 8'h00);
    tick(2);
    rd_en = 1'b1;
    expf(1, "R11 capture", 8'h04, 8'h04);
    tick(2);
    dma_pulse(2);
    tick(4);

    while (sbq.size() > 0) tick(1);
    finish_run();
  end

endmodule